// File: doc/BRIEF.md
# Polled Command/Response Mailbox Engine

This engine runs on the controller side of a mailbox held in shared memory. It reaches that memory through a byte-wide request port. An internal timer wakes the engine after a set number of idle cycles. On each wake-up the engine reads the command flag byte. When a host has posted a command, the engine first marks the response area as in progress and then waits for one more poll period. On the following wake-up it checks the command, carries out a power-cap update when the command asks for one, and writes a complete response. The hand-off happens in a fixed order: the response fields and data are written first, then the ready flag is set and the command flag is cleared, and finally a one-cycle message strobe is raised.

Command buffer bytes, counted from `CMD_BASE`:
- +0: flag
- +1: request id
- +2: command code
- +4: length, high byte
- +5: length, low byte
- +6, +7: value, big-endian

Response buffer bytes, counted from `CMD_BASE + RSP_OFS`:
- +0: flag
- +1: request id
- +2: command code
- +3: status
- +4, +5: length, big-endian
- +6, +7: data

The states are S_IDLE, S_RD_CFLAG, S_RD_RFLAG, S_WR_PROG, S_RD_ID, S_RD_CODE, S_RD_LENH, S_RD_LENL, S_RD_D0, S_RD_D1, S_EXEC, S_WR_ID, S_WR_CODE, S_WR_STAT, S_WR_LENH, S_WR_LENL, S_WR_D0, S_WR_D1, S_WR_RFLAG, S_WR_CFLAG and S_POST. The transitions are:
- S_IDLE goes to S_RD_CFLAG on a timer tick.
- S_RD_CFLAG goes to S_RD_RFLAG when the flag is 0x80. Otherwise it returns to S_IDLE.
- S_RD_RFLAG goes to S_WR_PROG when the response flag is 0. Otherwise it goes to S_RD_ID.
- S_WR_PROG returns to S_IDLE.
- S_RD_ID goes to S_RD_CODE.
- S_RD_CODE goes to S_EXEC when an internal error is pending or the code is not 0xD1. Otherwise it goes to S_RD_LENH.
- S_RD_LENH goes to S_RD_LENL.
- S_RD_LENL goes to S_RD_D0 when the length is exactly 2. Otherwise it goes to S_EXEC.
- S_RD_D0 goes to S_RD_D1, and S_RD_D1 goes to S_EXEC.
- The write states then run in order from S_EXEC: S_WR_ID, S_WR_CODE, S_WR_STAT, S_WR_LENH, S_WR_LENL.
- After S_WR_LENL the engine goes to S_WR_D0 and S_WR_D1 only when the reply carries data. It then continues with S_WR_RFLAG, S_WR_CFLAG and S_POST, and returns to S_IDLE.
- A memory error on any access sends the engine to S_IDLE.

Top module: `mbx_engine`

## Requirements
- R1: Reset values:
  - `cap_cur` 100 and `cap_type` 0x00.
  - `cap_hard_min` 10, `cap_soft_min` 20 and `cap_max` 100.
  - `ctrl_state` 0x03.
  - `mem_req` and `msg_post` low.
- R2: The engine issues its first read of the command flag at `CMD_BASE` after `POLL_CYCLES` clock edges following reset release. It then polls again after every `POLL_CYCLES` idle cycles. It acts only when the flag equals exactly 0x80; any other value causes no write.
- R3: If the response flag is 0x00 when a command is ready, the engine writes 0x02 to the response flag and nothing else. It completes the command on a later poll.
- R4: If the response flag is neither 0x00 nor 0x02 when a command is ready, the reply has status 0x15 and length 0, and the cap is left unchanged.
- R5: For code 0xD1 with a length other than 2, the reply has status 0x12. The reply data is the current cap as 2 big-endian bytes, and the cap is unchanged.
- R6: For code 0xD1 with value 0, the engine sets `cap_type` to 0x00 and `cap_cur` to 100.
- R7: For code 0xD1 with a nonzero value, the engine sets `cap_type` to 0x02 and `cap_cur` to the value clamped to the range 10..100.
- R8: A successful 0xD1 command replies with status 0x00, length 2 and the new cap in big-endian order. Any other code replies with status 0x11 and length 0.
- R9: Every reply copies the request id and the command code. The writes occur in this order:
  1. request id, command code and status;
  2. the length bytes;
  3. the data, when present;
  4. the response flag set to 0x01;
  5. the command flag set to 0x00.

  `msg_post` then pulses for exactly one cycle.
- R10: Each memory request moves one byte. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ready` is seen.
- R11: An access answered with `mem_err` ends that poll. After it, the engine issues no further memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 8 | Read byte |
| mem_err | input | 1 | Access failed (qualified by `mem_ready`) |
| msg_post | output | 1 | One-cycle strobe after a reply is handed off |
| cap_cur | output | 16 | Current power cap in watts |
| cap_type | output | 8 | Cap type: 0x00 none, 0x02 user set |
| cap_hard_min | output | 16 | Hard minimum cap |
| cap_soft_min | output | 16 | Soft minimum cap |
| cap_max | output | 16 | Maximum cap |
| ctrl_state | output | 8 | Controller state byte (0x03 active) |

## Verification
The hardest case to reach is the split handshake. A command must be caught after its in-progress mark has been written, and then stopped before the second poll can answer it. The bench watches its write log until the 0x02 mark appears, and in the same cycle withdraws the command flag in memory. A separate run lets both polls complete so the combined write sequence can be compared. The memory model stalls `mem_ready` in a pseudo-random pattern throughout, so that each request must be held across waits. An error is injected on the command-flag address to show that polling stops permanently.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_RD_CFLAG,
        S_RD_RFLAG,
        S_WR_PROG,
        S_RD_ID,
        S_RD_CODE,
        S_RD_LENH,
        S_RD_LENL,
        S_RD_D0,
        S_RD_D1,
        S_EXEC,
        S_WR_ID,
        S_WR_CODE,
        S_WR_STAT,
        S_WR_LENH,
        S_WR_LENL,
        S_WR_D0,
        S_WR_D1,
        S_WR_RFLAG,
        S_WR_CFLAG,
        S_POST
    } mbx_state_e;

    // flag values
    localparam logic [7:0] CFLAG_READY = 8'h80;
    localparam logic [7:0] RFLAG_IDLE  = 8'h00;
    localparam logic [7:0] RFLAG_BUSY  = 8'h02;
    localparam logic [7:0] RFLAG_DONE  = 8'h01;

    // command codes and reply status
    localparam logic [7:0] OP_SET_CAP  = 8'hD1;
    localparam logic [7:0] ST_OK       = 8'h00;
    localparam logic [7:0] ST_BAD_OP   = 8'h11;
    localparam logic [7:0] ST_BAD_LEN  = 8'h12;
    localparam logic [7:0] ST_INT_ERR  = 8'h15;

    // byte offsets inside each buffer
    localparam int OFS_FLAG = 0;
    localparam int OFS_ID   = 1;
    localparam int OFS_CODE = 2;
    localparam int OFS_STAT = 3;
    localparam int OFS_LENH = 4;
    localparam int OFS_LENL = 5;
    localparam int OFS_D0   = 6;
    localparam int OFS_D1   = 7;

    localparam logic [7:0] CTRL_ACTIVE = 8'h03;
    localparam logic [7:0] CAPT_NONE   = 8'h00;
    localparam logic [7:0] CAPT_USER   = 8'h02;

endpackage

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
    parameter int POLL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stop,
    output logic tick,
    output logic halted
);
    localparam int CNT_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            halted <= 1'b0;
        end else begin
            if (stop)
                halted <= 1'b1;
            if (!en || halted || stop)
                cnt <= '0;
            else if (cnt == LAST)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && !halted && (cnt == LAST);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R11

endmodule

// File: rtl/mbx_cap_unit.sv
module mbx_cap_unit
    import mbx_pkg::*;
#(
    parameter int CAP_HARD = 10,
    parameter int CAP_SOFT = 20,
    parameter int CAP_CEIL = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] value,
    output logic [15:0] cap_cur,
    output logic [7:0]  cap_type,
    output logic [15:0] cap_hard,
    output logic [15:0] cap_soft,
    output logic [15:0] cap_max
);
    localparam logic [15:0] HARD = 16'(CAP_HARD);
    localparam logic [15:0] SOFT = 16'(CAP_SOFT);
    localparam logic [15:0] CEIL = 16'(CAP_CEIL);

    logic [15:0] cap_nxt;
    logic [7:0]  type_nxt;

    always_comb begin
        if (value == 16'd0) begin
            type_nxt = CAPT_NONE;
            cap_nxt  = CEIL;
        end else begin
            type_nxt = CAPT_USER;
            if (value < HARD)
                cap_nxt = HARD;
            else if (value > CEIL)
                cap_nxt = CEIL;
            else
                cap_nxt = value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_cur  <= CEIL;
            cap_type <= CAPT_NONE;
        end else if (load) begin
            cap_cur  <= cap_nxt;
            cap_type <= type_nxt;
        end
    end

    assign cap_hard = HARD;
    assign cap_soft = SOFT;
    assign cap_max  = CEIL;

    AST_CAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_cur >= HARD) && (cap_cur <= CEIL)); // R7
    AST_CLEAR_TO_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (load && value == 16'd0) |=> (cap_type == CAPT_NONE) && (cap_cur == CEIL)); // R6
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cap_cur) && $stable(cap_type)); // R5

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
    import mbx_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter int              POLL_CYCLES = 1000,
    parameter logic [ADDR_W-1:0] CMD_BASE  = 16'h0B80,
    parameter logic [ADDR_W-1:0] RSP_OFS   = 16'h0100,
    parameter int              CAP_HARD    = 10,
    parameter int              CAP_SOFT    = 20,
    parameter int              CAP_CEIL    = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ready,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err,
    output logic              msg_post,
    output logic [15:0]       cap_cur,
    output logic [7:0]        cap_type,
    output logic [15:0]       cap_hard_min,
    output logic [15:0]       cap_soft_min,
    output logic [15:0]       cap_max,
    output logic [7:0]        ctrl_state
);
    localparam logic [ADDR_W-1:0] RSP_BASE = CMD_BASE + RSP_OFS;

    mbx_state_e state, nxt;

    logic       tick, halted;
    logic       acc_ok, acc_err;
    logic       int_err, len_ok;
    logic [7:0] req_id, op_code, len_h, val_h, val_l, status, status_calc;
    logic       has_data, cap_load;

    assign acc_ok  = mem_req && mem_ready && !mem_err;
    assign acc_err = mem_req && mem_ready && mem_err;

    mbx_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state == S_IDLE),
        .stop   (acc_err),
        .tick   (tick),
        .halted (halted)
    );

    mbx_cap_unit #(.CAP_HARD(CAP_HARD), .CAP_SOFT(CAP_SOFT), .CAP_CEIL(CAP_CEIL)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cap_load),
        .value    ({val_h, val_l}),
        .cap_cur  (cap_cur),
        .cap_type (cap_type),
        .cap_hard (cap_hard_min),
        .cap_soft (cap_soft_min),
        .cap_max  (cap_max)
    );

    assign ctrl_state = CTRL_ACTIVE;

    // reply classification
    always_comb begin
        if (int_err)
            status_calc = ST_INT_ERR;
        else if (op_code != OP_SET_CAP)
            status_calc = ST_BAD_OP;
        else if (!len_ok)
            status_calc = ST_BAD_LEN;
        else
            status_calc = ST_OK;
    end
    assign has_data = !int_err && (op_code == OP_SET_CAP);
    assign cap_load = (state == S_EXEC) && (status_calc == ST_OK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (tick) nxt = S_RD_CFLAG;
            S_RD_CFLAG: if (acc_ok) nxt = (mem_rdata == CFLAG_READY) ? S_RD_RFLAG : S_IDLE;
            S_RD_RFLAG: if (acc_ok) nxt = (mem_rdata == RFLAG_IDLE) ? S_WR_PROG : S_RD_ID;
            S_WR_PROG:  if (acc_ok) nxt = S_IDLE;
            S_RD_ID:    if (acc_ok) nxt = S_RD_CODE;
            S_RD_CODE:  if (acc_ok) nxt = (int_err || mem_rdata != OP_SET_CAP) ? S_EXEC : S_RD_LENH;
            S_RD_LENH:  if (acc_ok) nxt = S_RD_LENL;
            S_RD_LENL:  if (acc_ok) nxt = (len_h == 8'd0 && mem_rdata == 8'd2) ? S_RD_D0 : S_EXEC;
            S_RD_D0:    if (acc_ok) nxt = S_RD_D1;
            S_RD_D1:    if (acc_ok) nxt = S_EXEC;
            S_EXEC:     nxt = S_WR_ID;
            S_WR_ID:    if (acc_ok) nxt = S_WR_CODE;
            S_WR_CODE:  if (acc_ok) nxt = S_WR_STAT;
            S_WR_STAT:  if (acc_ok) nxt = S_WR_LENH;
            S_WR_LENH:  if (acc_ok) nxt = S_WR_LENL;
            S_WR_LENL:  if (acc_ok) nxt = has_data ? S_WR_D0 : S_WR_RFLAG;
            S_WR_D0:    if (acc_ok) nxt = S_WR_D1;
            S_WR_D1:    if (acc_ok) nxt = S_WR_RFLAG;
            S_WR_RFLAG: if (acc_ok) nxt = S_WR_CFLAG;
            S_WR_CFLAG: if (acc_ok) nxt = S_POST;
            S_POST:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
        if (acc_err)
            nxt = S_IDLE;
    end

    // captured command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_err <= 1'b0;
            len_ok  <= 1'b0;
            req_id  <= '0;
            op_code <= '0;
            len_h   <= '0;
            val_h   <= '0;
            val_l   <= '0;
            status  <= '0;
        end else begin
            unique case (state)
                S_RD_CFLAG: if (acc_ok) begin
                    int_err <= 1'b0;
                    len_ok  <= 1'b0;
                end
                S_RD_RFLAG: if (acc_ok) int_err <= (mem_rdata != RFLAG_BUSY);
                S_RD_ID:    if (acc_ok) req_id  <= mem_rdata;
                S_RD_CODE:  if (acc_ok) op_code <= mem_rdata;
                S_RD_LENH:  if (acc_ok) len_h   <= mem_rdata;
                S_RD_LENL:  if (acc_ok) len_ok  <= (len_h == 8'd0) && (mem_rdata == 8'd2);
                S_RD_D0:    if (acc_ok) val_h   <= mem_rdata;
                S_RD_D1:    if (acc_ok) val_l   <= mem_rdata;
                S_EXEC:     status <= status_calc;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = CMD_BASE;
        mem_wdata = 8'h00;
        msg_post  = 1'b0;
        unique case (state)
            S_RD_CFLAG: begin mem_req = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_FLAG); end
            S_RD_RFLAG: begin mem_req = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_FLAG); end
            S_WR_PROG:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_FLAG); mem_wdata = RFLAG_BUSY; end
            S_RD_ID:    begin mem_req = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_ID); end
            S_RD_CODE:  begin mem_req = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_CODE); end
            S_RD_LENH:  begin mem_req = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_LENH); end
            S_RD_LENL:  begin mem_req = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_LENL); end
            S_RD_D0:    begin mem_req = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_D0); end
            S_RD_D1:    begin mem_req = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_D1); end
            S_WR_ID:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_ID);   mem_wdata = req_id; end
            S_WR_CODE:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_CODE); mem_wdata = op_code; end
            S_WR_STAT:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_STAT); mem_wdata = status; end
            S_WR_LENH:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_LENH); mem_wdata = 8'h00; end
            S_WR_LENL:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_LENL); mem_wdata = has_data ? 8'd2 : 8'd0; end
            S_WR_D0:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_D0);   mem_wdata = cap_cur[15:8]; end
            S_WR_D1:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_D1);   mem_wdata = cap_cur[7:0]; end
            S_WR_RFLAG: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = RSP_BASE + ADDR_W'(OFS_FLAG); mem_wdata = RFLAG_DONE; end
            S_WR_CFLAG: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = CMD_BASE + ADDR_W'(OFS_FLAG); mem_wdata = 8'h00; end
            S_POST:     msg_post = 1'b1;
            default: ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
    AST_POST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_post |=> !msg_post); // R9
    AST_POST_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        msg_post |-> $past(mem_req && mem_we && mem_addr == CMD_BASE && mem_wdata == 8'h00)); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req); // R11

endmodule

// File: tb/mbx_engine_tb.sv
module mbx_engine_tb;
    localparam int AW   = 10;
    localparam int POLL = 20;
    localparam int CB   = 'h040;
    localparam int RO   = 'h080;
    localparam int RB   = CB + RO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req, mem_we, mem_ready, mem_err, msg_post;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata, cap_type, ctrl_state;
    logic [15:0]   cap_cur, cap_hard_min, cap_soft_min, cap_max;

    always #2 clk = ~clk;

    mbx_engine #(
        .ADDR_W(AW), .POLL_CYCLES(POLL),
        .CMD_BASE(AW'(CB)), .RSP_OFS(AW'(RO))
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .msg_post(msg_post), .cap_cur(cap_cur), .cap_type(cap_type),
        .cap_hard_min(cap_hard_min), .cap_soft_min(cap_soft_min), .cap_max(cap_max),
        .ctrl_state(ctrl_state)
    );

    // memory model
    logic [7:0] mem [0:(1<<AW)-1];
    logic [7:0] lfsr = 8'h5A;
    bit   stall_en = 0, err_arm = 0, err_seen = 0;
    int   err_addr = 0;
    int   wa_q[$], wd_q[$], ea_q[$], ed_q[$];
    int   post_cnt = 0, post_at = -1, exp_posts = 0, req_after = 0;
    int   nchk = 0, nfail = 0, cyc = 0;
    int   exp_cap = 100, exp_type = 0;
    bit   settled = 0;

    assign mem_ready = mem_req && (lfsr[0] || !stall_en);
    assign mem_rdata = mem[mem_addr];
    assign mem_err   = mem_ready && err_arm && (int'(mem_addr) == err_addr);

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_req && mem_ready && mem_err) err_seen <= 1'b1;
        if (mem_req && mem_ready && mem_we && !mem_err) begin
            mem[mem_addr] <= mem_wdata;
            wa_q.push_back(int'(mem_addr));
            wd_q.push_back(int'(mem_wdata));
        end
        if (msg_post) begin
            post_cnt = post_cnt + 1;
            post_at  = wa_q.size();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    logic          p_req = 0, p_rdy = 0, p_we = 0;
    logic [AW-1:0] p_addr = '0;
    logic [7:0]    p_wd = '0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_req && !p_rdy)
                check(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wd,
                      "R10 request held during stall", int'(mem_addr), int'(p_addr));
            if (settled) begin
                check(cap_cur == 16'(exp_cap), "R7 cap_cur vs model", int'(cap_cur), exp_cap);
                check(cap_type == 8'(exp_type), "R6 cap_type vs model", int'(cap_type), exp_type);
            end
            if (err_seen && mem_req) req_after++;
        end
        p_req = mem_req; p_rdy = mem_ready; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    function automatic int model_cap(input int v);
        if (v == 0) return 100;
        if (v < 10) return 10;
        if (v > 100) return 100;
        return v;
    endfunction

    task automatic push_exp(input int a, input int d);
        ea_q.push_back(a);
        ed_q.push_back(d);
    endtask

    task automatic exp_reply(input int id, input int code, input int st, input bit data, input int capv);
        push_exp(RB + 1, id);
        push_exp(RB + 2, code);
        push_exp(RB + 3, st);
        push_exp(RB + 4, 0);
        push_exp(RB + 5, data ? 2 : 0);
        if (data) begin
            push_exp(RB + 6, (capv >> 8) & 255);
            push_exp(RB + 7, capv & 255);
        end
        push_exp(RB, 1);
        push_exp(CB, 0);
        exp_posts = 1;
    endtask

    task automatic arm(input int rflag, input int id, input int code, input int lh,
                       input int ll, input int d0, input int d1);
        @(negedge clk);
        settled = 0;
        wa_q.delete(); wd_q.delete(); ea_q.delete(); ed_q.delete();
        post_cnt = 0; post_at = -1; exp_posts = 0;
        mem[RB]     <= 8'(rflag);
        mem[CB + 1] <= 8'(id);
        mem[CB + 2] <= 8'(code);
        mem[CB + 4] <= 8'(lh);
        mem[CB + 5] <= 8'(ll);
        mem[CB + 6] <= 8'(d0);
        mem[CB + 7] <= 8'(d1);
        mem[CB]     <= 8'h80;
    endtask

    task automatic cmp_log(input string tag);
        check(wa_q.size() == ea_q.size(), {tag, " write count"}, wa_q.size(), ea_q.size());
        for (int i = 0; i < ea_q.size(); i++)
            if (i < wa_q.size())
                check(wa_q[i] == ea_q[i] && wd_q[i] == ed_q[i], {tag, " R9 write order"},
                      (wa_q[i] << 8) | wd_q[i], (ea_q[i] << 8) | ed_q[i]);
        check(post_cnt == exp_posts, {tag, " R9 msg_post count"}, post_cnt, exp_posts);
        if (exp_posts != 0)
            check(post_at == ea_q.size(), {tag, " R9 post after last write"}, post_at, ea_q.size());
    endtask

    task automatic run_cmd(input string tag, input int rflag, input int id, input int code,
                           input int lh, input int ll, input int val,
                           input int st, input bit data, input int new_cap, input int new_type);
        arm(rflag, id, code, lh, ll, (val >> 8) & 255, val & 255);
        if (rflag == 0) push_exp(RB, 2);
        exp_reply(id, code, st, data, new_cap);
        repeat (170) @(negedge clk);
        cmp_log(tag);
        exp_cap = new_cap;
        exp_type = new_type;
        settled = 1;
    endtask

    initial begin
        int n;
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(cap_cur == 16'd100, "R1 cap_cur", int'(cap_cur), 100);
        check(cap_type == 8'h00, "R1 cap_type", int'(cap_type), 0);
        check(cap_hard_min == 16'd10, "R1 hard min", int'(cap_hard_min), 10);
        check(cap_soft_min == 16'd20, "R1 soft min", int'(cap_soft_min), 20);
        check(cap_max == 16'd100, "R1 max", int'(cap_max), 100);
        check(ctrl_state == 8'h03, "R1 ctrl_state", int'(ctrl_state), 3);
        check(!mem_req && !msg_post, "R1 idle outputs", int'(mem_req), 0);
        rst_n = 1'b1;
        settled = 1;
        // R2 first poll latency
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); #1; n++;
            if (mem_req) break;
        end
        check(n == POLL && mem_addr == AW'(CB) && !mem_we, "R2 first poll", n, POLL);
        // R2 flag zero and flag 0x81 cause no write
        repeat (100) @(negedge clk);
        check(wa_q.size() == 0, "R2 flag 0x00 no write", wa_q.size(), 0);
        stall_en = 1;
        mem[CB] <= 8'h81;
        repeat (100) @(negedge clk);
        check(wa_q.size() == 0, "R2 flag 0x81 no write", wa_q.size(), 0);
        check(mem[CB] == 8'h81, "R2 flag 0x81 untouched", int'(mem[CB]), 'h81);

        // R3 in-progress mark only, then withdraw command
        arm(0, 'h21, 'hD1, 0, 2, 0, 40);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (wa_q.size() != 0) break;
        end
        mem[CB] <= 8'h00;
        repeat (120) @(negedge clk);
        check(wa_q.size() == 1, "R3 single write", wa_q.size(), 1);
        if (wa_q.size() != 0)
            check(wa_q[0] == RB && wd_q[0] == 2, "R3 progress mark", (wa_q[0] << 8) | wd_q[0], (RB << 8) | 2);
        check(post_cnt == 0, "R3 no post", post_cnt, 0);
        settled = 1;

        // R3 + R8 full two-tick handshake, value 50
        run_cmd("R3 two-tick R8", 0, 'h31, 'hD1, 0, 2, 50, 'h00, 1, model_cap(50), 2);
        // R6 clear on zero
        run_cmd("R6 zero", 2, 'h32, 'hD1, 0, 2, 0, 'h00, 1, 100, 0);
        // R7 clamp low
        run_cmd("R7 low clamp", 2, 'h33, 'hD1, 0, 2, 3, 'h00, 1, model_cap(3), 2);
        // R5 bad length 3 returns current cap 10
        run_cmd("R5 len 3", 2, 'h34, 'hD1, 0, 3, 77, 'h12, 1, 10, 2);
        // R5 high length byte nonzero
        run_cmd("R5 len 0x0102", 2, 'h35, 'hD1, 1, 2, 77, 'h12, 1, 10, 2);
        // R7 clamp high (512)
        run_cmd("R7 high clamp", 2, 'h36, 'hD1, 0, 2, 'h0200, 'h00, 1, model_cap('h200), 2);
        // R7 lower bound exact
        run_cmd("R7 bound 10", 2, 'h37, 'hD1, 0, 2, 10, 'h00, 1, 10, 2);
        // R7 upper bound exact
        run_cmd("R7 bound 100", 2, 'h38, 'hD1, 0, 2, 100, 'h00, 1, 100, 2);
        // R8 unknown command
        run_cmd("R8 unknown op", 2, 'h39, 'h55, 0, 2, 20, 'h11, 0, 100, 2);
        // R4 stale response flag, valid-looking command ignored
        run_cmd("R4 stale flag", 1, 'h3A, 'hD1, 0, 2, 30, 'h15, 0, 100, 2);

        // R11 memory error halts polling
        @(negedge clk);
        wa_q.delete(); wd_q.delete();
        err_addr = CB;
        err_arm = 1;
        arm(2, 'h3B, 'hD1, 0, 2, 0, 44);
        wa_q.delete(); wd_q.delete();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (err_seen) break;
        end
        check(err_seen, "R11 error injected", int'(err_seen), 1);
        settled = 1;
        req_after = 0;
        repeat (6 * POLL) @(negedge clk);
        check(req_after == 0, "R11 no requests after error", req_after, 0);
        check(wa_q.size() == 0, "R11 no writes after error", wa_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule